// File: doc/BRIEF.md
# TDM Channel Slot Serial Transceiver

This block moves one word per frame between a parallel core and a time-division serial bus. The bus carries a bit clock, an active-low frame strobe and an active-low channel strobe. The block is active only while both strobes are low, and that time is its channel window. During the window it shifts a transmit word out on a serial line that has an output-enable. In the same clock cycles it shifts the incoming word in from the serial input.

The transmit word is taken from the parallel input on the first bit of the window. Changes to that input later in the window do not affect the bits that are sent. After the last bit of a word, the received word goes into a holding register and a valid pulse lasts one cycle. A window that closes early throws away the partial word. A window that stays open for more than one word length starts a new word. Arbitration of the bus and generation of the frame timing are handled outside the block.

Top module: `tdm_slot_xcvr`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset with both strobes high, sdata_oe_o is 0, rx_valid_o is 0 and rx_word_o is 8'h00.
- R2: sdata_oe_o is 1 exactly in the cycles where frame_ni and chan_ni are both low. If only one strobe is low, the output stays in high impedance.
- R3: In the first cycle of a window, sdata_o carries bit 7 of tx_word_i. In each following cycle of that word, sdata_o carries the next lower bit (MSB first). Bit 0 is carried in the eighth cycle.
- R4: The transmit word is latched on the first cycle of each word. Changes to tx_word_i during bit cycles 2 to 8 do not change the bits on sdata_o.
- R5: sdata_i is sampled on each rising clock edge inside the window. The first sample becomes rx_word_o bit 7 and the eighth sample becomes bit 0. In the cycle after the edge that samples the eighth bit, rx_word_o holds the new word and rx_valid_o is 1.
- R6: rx_valid_o stays high for exactly one cycle per completed word.
- R7: If the window closes before eight bits, rx_valid_o is not raised and rx_word_o keeps its previous value. The next window starts again from bit 7 of a newly latched word.
- R8: If the window stays open for more than eight cycles, cycle 9 starts a new word. tx_word_i is latched again and sent MSB first, and a second received word is delivered with its own valid pulse.
- R9: Outside the window, rx_word_o holds its value and sdata_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Frame strobe, active low |
| chan_ni | input | 1 | Channel strobe, active low |
| sdata_i | input | 1 | Serial data from the bus |
| tx_word_i | input | 8 | Parallel word to transmit |
| sdata_o | output | 1 | Serial data to the bus, valid while sdata_oe_o is high |
| sdata_oe_o | output | 1 | Output-enable for the three-state driver |
| rx_word_o | output | 8 | Last completed received word |
| rx_valid_o | output | 1 | One-cycle pulse when rx_word_o updates |

## Verification
sdata_oe_o and sdata_o are combinational from the strobes and the latched word, so they are due in the same cycle in which the strobes fall. The bench drives its inputs on the falling clock edge and samples these outputs one nanosecond later, before the next rising edge. rx_word_o and rx_valid_o change on the rising edge that samples the eighth bit. The bench therefore expects the valid pulse at the falling edge that follows, and expects it to be gone one cycle later. Early close, window lengths of two words, and strobe patterns that open only half of the window are each checked at the cycle where a wrong result would first appear.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

  typedef struct packed {
    logic active;  // both strobes low
    logic first;   // first bit of a word
    logic last;    // final bit of a word
  } slot_t;

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
  import tdm_slot_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  frame_ni,
  input  logic  chan_ni,
  output slot_t slot_o
);

  localparam int unsigned CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active;

  assign active        = ~frame_ni & ~chan_ni;
  assign slot_o.active = active;
  assign slot_o.first  = active && (cnt_q == '0);
  assign slot_o.last   = active && (cnt_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!active)     cnt_q <= '0;  // early close drops the word
    else if (slot_o.last) cnt_q <= '0;  // long window starts a new word
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // R7: a closed window always restarts at bit 0
  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (cnt_q == '0));

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_slot_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  slot_t             slot_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              sdata_o,
  output logic              sdata_oe_o
);

  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            sh_q <= '0;
    else if (slot_i.first)  sh_q <= tx_word_i << 1;
    else if (slot_i.active) sh_q <= sh_q << 1;
  end

  // MSB is sent straight from the input on the first bit, no setup cycle
  assign sdata_o    = slot_i.first ? tx_word_i[WORD_W-1] : sh_q[WORD_W-1];
  assign sdata_oe_o = slot_i.active;

  // R4: second bit comes from the word latched a cycle earlier
  p_word_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i.active && !slot_i.first && $past(slot_i.first))
      |-> (sdata_o == $past(tx_word_i[WORD_W-2])));

endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_slot_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  slot_t             slot_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);

  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;
  logic [WORD_W-1:0] sh_next;

  assign sh_next = {sh_q[WORD_W-2:0], sdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= slot_i.last;
      if (slot_i.active) sh_q   <= sh_next;
      if (slot_i.last)   word_q <= sh_next;
    end
  end

  assign rx_word_o  = word_q;
  assign rx_valid_o = valid_q;

  // R5: last bit is followed by a valid pulse
  p_valid_due_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i.last |=> rx_valid_o);

  // R6: single-cycle pulse
  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R9: held word only moves together with a valid pulse
  p_word_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_word_o) |-> rx_valid_o);

endmodule

// File: rtl/tdm_slot_xcvr.sv
module tdm_slot_xcvr
  import tdm_slot_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic              chan_ni,
  input  logic              sdata_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);

  slot_t slot;

  tdm_slot_timer #(.WORD_W(WORD_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_ni (frame_ni),
    .chan_ni  (chan_ni),
    .slot_o   (slot)
  );

  tdm_slot_tx #(.WORD_W(WORD_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_i     (slot),
    .tx_word_i  (tx_word_i),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o)
  );

  tdm_slot_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_i     (slot),
    .sdata_i    (sdata_i),
    .rx_word_o  (rx_word_o),
    .rx_valid_o (rx_valid_o)
  );

  // R2: driver enabled only inside the window
  p_oe_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdata_oe_o |-> (!frame_ni && !chan_ni));

endmodule

// File: tb/tb_tdm_slot_xcvr.sv
module tb_tdm_slot_xcvr;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_ni = 1'b1;
  logic       chan_ni = 1'b1;
  logic       sdata_i = 1'b0;
  logic [7:0] tx_word_i = 8'h00;
  logic       sdata_o, sdata_oe_o, rx_valid_o;
  logic [7:0] rx_word_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_rx = 8'h00;

  always #2 clk = ~clk;

  tdm_slot_xcvr dut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_ni(frame_ni), .chan_ni(chan_ni),
    .sdata_i(sdata_i), .tx_word_i(tx_word_i), .sdata_o(sdata_o),
    .sdata_oe_o(sdata_oe_o), .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Opens a window of nbits cycles. tx2/rx2 hold up to two words, MSB first.
  // Off-boundary cycles scramble tx_word_i to exercise R4.
  task automatic run_window(input logic [15:0] tx2, input logic [15:0] rx2,
                            input int nbits, input string req);
    for (int i = 0; i < nbits; i++) begin
      int s = i / 8;
      int b = 7 - (i % 8);
      logic [7:0] txw = tx2[15 - 8*s -: 8];
      logic [7:0] rxw = rx2[15 - 8*s -: 8];
      @(negedge clk);
      frame_ni  = 1'b0;
      chan_ni   = 1'b0;
      sdata_i   = rxw[b];
      tx_word_i = (i % 8 == 0) ? txw : (txw ^ 8'hA5 ^ 8'(i));
      #1;
      chk(sdata_oe_o == 1'b1, "R2", "oe in window", sdata_oe_o, 1);
      chk(sdata_o == txw[b], req, "serial bit", sdata_o, txw[b]);
      if (i > 0 && i % 8 == 0) begin
        exp_rx = rx2[15 - 8*(s-1) -: 8];
        chk(rx_valid_o == 1'b1, "R8", "valid mid window", rx_valid_o, 1);
        chk(rx_word_o == exp_rx, "R8", "word mid window", rx_word_o, exp_rx);
      end else begin
        chk(rx_valid_o == 1'b0, "R6", "no valid", rx_valid_o, 0);
      end
    end
    @(negedge clk);
    frame_ni = 1'b1;
    chan_ni  = 1'b1;
    sdata_i  = ~sdata_i;
    #1;
    chk(sdata_oe_o == 1'b0, "R2", "oe after window", sdata_oe_o, 0);
    if (nbits % 8 == 0) begin
      exp_rx = rx2[15 - 8*((nbits/8)-1) -: 8];
      chk(rx_valid_o == 1'b1, "R5", "valid after word", rx_valid_o, 1);
    end else begin
      chk(rx_valid_o == 1'b0, "R7", "no valid on early close", rx_valid_o, 0);
    end
    chk(rx_word_o == exp_rx, (nbits % 8 == 0) ? "R5" : "R7", "rx word",
        rx_word_o, exp_rx);
    @(negedge clk);
    sdata_i = ~sdata_i;
    #1;
    chk(rx_valid_o == 1'b0, "R6", "valid dropped", rx_valid_o, 0);
    chk(rx_word_o == exp_rx, "R9", "word held idle", rx_word_o, exp_rx);
  endtask

  task automatic t_reset;
    #1;
    chk(sdata_oe_o == 1'b0, "R1", "oe in reset", sdata_oe_o, 0);
    chk(rx_valid_o == 1'b0, "R1", "valid in reset", rx_valid_o, 0);
    chk(rx_word_o == 8'h00, "R1", "word in reset", rx_word_o, 0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    chk(sdata_oe_o == 1'b0, "R1", "oe after reset", sdata_oe_o, 0);
    chk(rx_word_o == 8'h00, "R1", "word after reset", rx_word_o, 0);
  endtask

  task automatic t_basic;
    run_window({8'hB4, 8'h00}, {8'h3C, 8'h00}, 8, "R3");
    run_window({8'h01, 8'h00}, {8'hFF, 8'h00}, 8, "R3");
    run_window({8'h80, 8'h00}, {8'h81, 8'h00}, 8, "R4");
  endtask

  task automatic t_half_strobe;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      frame_ni = (i < 3);
      chan_ni  = (i >= 3);
      sdata_i  = i[0];
      #1;
      chk(sdata_oe_o == 1'b0, "R2", "oe one strobe low", sdata_oe_o, 0);
      chk(rx_valid_o == 1'b0, "R9", "no valid outside", rx_valid_o, 0);
    end
    @(negedge clk);
    frame_ni = 1'b1; chan_ni = 1'b1;
    #1;
    chk(rx_word_o == exp_rx, "R9", "word kept", rx_word_o, exp_rx);
    run_window({8'h5A, 8'h00}, {8'hC3, 8'h00}, 8, "R9");
  endtask

  task automatic t_abort;
    run_window({8'hE7, 8'h00}, {8'h12, 8'h00}, 5, "R7");
    run_window({8'h69, 8'h00}, {8'h96, 8'h00}, 8, "R7");
  endtask

  task automatic t_long;
    run_window({8'hD2, 8'h4B}, {8'hAA, 8'h55}, 16, "R8");
    run_window({8'h0F, 8'hF0}, {8'h77, 8'h88}, 11, "R8");
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_half_strobe();
    t_abort();
    t_long();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule